// File: doc/BRIEF.md
# Memory-Mapped Byte UART Register Block

This block sits on a simple word-addressed bus as a slave and connects a processor to a byte-wide receive stream and a byte-wide transmit stream. Incoming bytes arrive through a valid/ready handshake and are queued in a small receive FIFO. Software drains that FIFO one byte per read of the receive-data word. Writing the transmit-data word hands one byte to a single-entry holding register, which offers it downstream through a second valid/ready handshake.

Four 32-bit word registers are decoded from address bits [3:2]. Index 0 is receive data, index 1 is transmit data, index 2 is status and index 3 is control. The status word reports FIFO and transmit occupancy and an interrupt-pending flag. The control word provides an interrupt enable and two self-clearing flush actions, one for each direction. A single level-sensitive interrupt output combines the pending flag with the enable. Line framing, baud timing and error detection belong to other blocks, so the three error bits of status always read 0.

Top module: `uart_reg_block`

## Requirements
- R1: After reset the status word reads 0x00000004 (only TX empty set), the control word reads 0, `rx_ready` is 1, and `tx_valid` and `irq` are 0.
- R2: The register index is `bus_addr[3:2]` and bits [1:0] are ignored. A control write stores all 32 bits, and a control read returns them.
- R3: Status bit 0 (RX valid) is 1 exactly when the receive FIFO holds at least one byte. A read of index 0 returns the oldest queued byte, zero-extended, and removes it, so bytes leave in arrival order.
- R4: The FIFO holds 8 bytes. Status bit 1 (RX full) is 1 when it holds 8. `rx_ready` is 0 while it is full, and a byte offered then is not taken.
- R5: A read of index 0 with the FIFO empty returns the byte stored in the slot at the write position and does not change the occupancy.
- R6: A control write with bit 1 set empties the FIFO and resets its write position in that same cycle. `rx_ready` is 0 during that write, and the written value is kept in the control register.
- R7: A write to the status index changes no state.
- R8: A write to index 1 loads `bus_wdata[7:0]` into the holding register when it is free. From the next cycle `tx_valid` is 1 and `tx_byte` stays stable until `tx_ready` is seen. Status bit 2 (TX empty) is 1 when the holding register is free, and status bit 3 (TX full) is 1 when it holds a byte.
- R9: A transmit write while the holding register is occupied and not being accepted discards the new byte.
- R10: A control write with bit 0 set discards the held transmit byte, so `tx_valid` is 0 in the following cycle.
- R11: Status bit 4 (interrupt pending) sets on every transmit write and on every cycle in which the FIFO is non-empty. A status read clears it, and it sets again one cycle later if the FIFO is still non-empty.
- R12: `irq` is 1 only when interrupt pending and control bit 4 (interrupt enable) are both 1.
- R13: Status bits 5, 6 and 7 (overrun, frame, parity) and all bits above 7 always read 0.
- R14: A read of index 1 returns the full 32-bit value of the last transmit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| rx_valid | input | 1 | Incoming byte offered |
| rx_ready | output | 1 | Block can take a byte this cycle |
| rx_byte | input | BYTE_W | Incoming byte |
| tx_valid | output | 1 | Held byte offered downstream |
| tx_ready | input | 1 | Downstream takes the byte |
| tx_byte | output | BYTE_W | Held transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker examines on every cycle the properties that depend only on the current and previous cycle. These are the ready/occupancy relation and the occupancy bound, the same-cycle flush of the FIFO, the single-step decrement on a pop, the stability of an unaccepted transmit byte, the effect of a transmit flush, the constant-zero error bits, and the interrupt following a non-empty FIFO when it is enabled. The bench scenarios cover what only a sequence can show: the FIFO returns bytes in arrival order, an empty read returns stale data without underflow, the read-clear-reassert pattern of the pending bit, a second transmit write is discarded while the first byte waits, and status writes have no effect.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;

   // register word index, taken from byte address bits [3:2]
   typedef enum logic [1:0] {
      REG_RXD  = 2'd0,
      REG_TXD  = 2'd1,
      REG_STAT = 2'd2,
      REG_CTRL = 2'd3
   } reg_sel_e;

   // status word bit positions
   localparam int ST_RXV = 0;
   localparam int ST_RXF = 1;
   localparam int ST_TXE = 2;
   localparam int ST_TXF = 3;
   localparam int ST_IP  = 4;
   localparam int ST_OVR = 5;
   localparam int ST_FRM = 6;
   localparam int ST_PAR = 7;

   // control word bit positions
   localparam int CT_TXCLR = 0;
   localparam int CT_RXCLR = 1;
   localparam int CT_IEN   = 4;

endpackage

// File: rtl/urb_rx_fifo.sv
module urb_rx_fifo #(
   parameter int DEPTH  = 8,
   parameter int BYTE_W = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [BYTE_W-1:0] push_data,
   input  logic              pop,
   input  logic              flush,
   output logic [BYTE_W-1:0] head_data,
   output logic [CNT_W-1:0]  count,
   output logic              can_take
);

   logic [BYTE_W-1:0] slot [DEPTH];
   logic [PTR_W-1:0]  wptr;
   logic [PTR_W-1:0]  rptr;
   logic              take;
   logic              give;

   assign can_take = (count < CNT_W'(DEPTH)) && !flush;
   assign take     = push && can_take;
   assign give     = pop && (count != '0) && !flush;
   assign rptr     = wptr - PTR_W'(count);
   assign head_data = slot[rptr];

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (take && (wptr == PTR_W'(i))) begin
            slot[i] <= push_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         count <= '0;
      end else if (flush) begin
         wptr  <= '0;
         count <= '0;
      end else begin
         if (take) begin
            wptr <= wptr + 1'b1;
         end
         case ({take, give})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/urb_tx_hold.sv
module urb_tx_hold #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_data,
   input  logic              drop,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   input  logic              out_ready
);

   logic room;

   // free now, or emptied by the downstream in this very cycle
   assign room = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (drop) begin
         out_valid <= 1'b0;
      end else if (load && room) begin
         out_valid <= 1'b1;
         out_data  <= load_data;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/uart_reg_block.sv
module uart_reg_block
   import uart_reg_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int BYTE_W     = 8,
   parameter int FIFO_DEPTH = 8,
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              irq
);

   // elaboration-time parameter checks
   if (DATA_W < ST_PAR + 1) begin : g_bad_data_w
      $error("DATA_W must cover the status and control bits");
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("ADDR_W must reach address bit 3");
   end
   if (BYTE_W > DATA_W) begin : g_bad_byte_w
      $error("BYTE_W must not exceed DATA_W");
   end
   if ((FIFO_DEPTH < 2) || (FIFO_DEPTH != (1 << $clog2(FIFO_DEPTH)))) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two of at least 2");
   end

   reg_sel_e          sel;
   logic              acc_wr, acc_rd;
   logic              wr_txd, wr_ctrl, rd_rxd, rd_stat;
   logic              flush_rx, drop_tx;
   logic [BYTE_W-1:0] head_data;
   logic [CNT_W-1:0]  rx_count;
   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] txd_q;
   logic              ip_q;
   logic [DATA_W-1:0] stat_w;
   logic              unused_addr;

   assign sel         = reg_sel_e'(bus_addr[3:2]);
   assign unused_addr = ^bus_addr;
   assign acc_wr      = bus_en && bus_we;
   assign acc_rd      = bus_en && !bus_we;
   assign wr_txd      = acc_wr && (sel == REG_TXD);
   assign wr_ctrl     = acc_wr && (sel == REG_CTRL);
   assign rd_rxd      = acc_rd && (sel == REG_RXD);
   assign rd_stat     = acc_rd && (sel == REG_STAT);
   assign flush_rx    = wr_ctrl && bus_wdata[CT_RXCLR];
   assign drop_tx     = wr_ctrl && bus_wdata[CT_TXCLR];

   urb_rx_fifo #(
      .DEPTH  (FIFO_DEPTH),
      .BYTE_W (BYTE_W)
   ) u_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rx_valid),
      .push_data (rx_byte),
      .pop       (rd_rxd),
      .flush     (flush_rx),
      .head_data (head_data),
      .count     (rx_count),
      .can_take  (rx_ready)
   );

   urb_tx_hold #(
      .BYTE_W (BYTE_W)
   ) u_tx_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_txd),
      .load_data (bus_wdata[BYTE_W-1:0]),
      .drop      (drop_tx),
      .out_valid (tx_valid),
      .out_data  (tx_byte),
      .out_ready (tx_ready)
   );

   // control and transmit-data words; status writes fall through unused
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         txd_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q <= bus_wdata;
         end
         if (wr_txd) begin
            txd_q <= bus_wdata;
         end
      end
   end

   // interrupt-pending flag: a status read wins for one cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ip_q <= 1'b0;
      end else if (rd_stat) begin
         ip_q <= 1'b0;
      end else if (wr_txd || (rx_count != '0)) begin
         ip_q <= 1'b1;
      end
   end

   always_comb begin
      stat_w         = '0;
      stat_w[ST_RXV] = (rx_count != '0);
      stat_w[ST_RXF] = (rx_count == CNT_W'(FIFO_DEPTH));
      stat_w[ST_TXE] = !tx_valid;
      stat_w[ST_TXF] = tx_valid;
      stat_w[ST_IP]  = ip_q;
      stat_w[ST_OVR] = 1'b0;
      stat_w[ST_FRM] = 1'b0;
      stat_w[ST_PAR] = 1'b0;
   end

   always_comb begin
      case (sel)
         REG_RXD:  bus_rdata = {{(DATA_W - BYTE_W){1'b0}}, head_data};
         REG_TXD:  bus_rdata = txd_q;
         REG_STAT: bus_rdata = stat_w;
         default:  bus_rdata = ctrl_q;
      endcase
   end

   assign irq = ip_q && ctrl_q[CT_IEN];

endmodule

// File: rtl/urb_checker.sv
module urb_checker #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int DEPTH  = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [1:0]        bus_idx,
   input logic [1:0]        clr_bits,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic [BYTE_W-1:0] tx_byte,
   input logic              irq,
   input logic [CNT_W-1:0]  rx_count,
   input logic              ien
);

   logic ctl_wr, stat_rd, rxd_rd;
   assign ctl_wr  = bus_en && bus_we && (bus_idx == 2'd3);
   assign stat_rd = bus_en && !bus_we && (bus_idx == 2'd2);
   assign rxd_rd  = bus_en && !bus_we && (bus_idx == 2'd0);

   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= CNT_W'(DEPTH));

   assert_ready_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> (rx_count < CNT_W'(DEPTH)));

   assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rxd_rd && (rx_count != '0) && !(rx_valid && rx_ready)) |=>
         (rx_count == $past(rx_count) - 1'b1));

   assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && clr_bits[1]) |=> (rx_count == '0));

   assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !(ctl_wr && clr_bits[0])) |=>
         (tx_valid && $stable(tx_byte)));

   assert_tx_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && clr_bits[0]) |=> !tx_valid);

   assert_err_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |-> ((bus_rdata >> 5) == '0));

   assert_irq_follows_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ien && (rx_count != '0) && !stat_rd && !ctl_wr) |=> irq);

   assert_irq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !ien |-> !irq);

endmodule

bind uart_reg_block urb_checker #(
   .DATA_W (DATA_W),
   .BYTE_W (BYTE_W),
   .DEPTH  (FIFO_DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_en    (bus_en),
   .bus_we    (bus_we),
   .bus_idx   (bus_addr[3:2]),
   .clr_bits  (bus_wdata[1:0]),
   .bus_rdata (bus_rdata),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .tx_byte   (tx_byte),
   .irq       (irq),
   .rx_count  (rx_count),
   .ien       (ctrl_q[4])
);

// File: tb/sim_uart_reg_block.sv
module sim_uart_reg_block;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_valid = 1'b0;
   logic        rx_ready;
   logic [7:0]  rx_byte = '0;
   logic        tx_valid;
   logic        tx_ready = 1'b0;
   logic [7:0]  tx_byte;
   logic        irq;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   // bench reference of the receive queue
   logic [7:0] m_mem [8];
   int         m_wp = 0;
   int         m_cnt = 0;
   logic       last_rdy;
   logic [31:0] rd;

   always #2 clk = ~clk;   // 250 MHz

   uart_reg_block u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .rx_valid  (rx_valid),
      .rx_ready  (rx_ready),
      .rx_byte   (rx_byte),
      .tx_valid  (tx_valid),
      .tx_ready  (tx_ready),
      .tx_byte   (tx_byte),
      .irq       (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_stat_low(input int cnt);
      logic [31:0] v;
      v = 32'h4;
      if (cnt != 0) v[0] = 1'b1;
      if (cnt == 8) v[1] = 1'b1;
      return v;
   endfunction

   // each task starts just after a negedge and ends at the next negedge
   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      #1 last_rdy = rx_ready;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic push(input logic [7:0] b);
      rx_valid = 1'b1; rx_byte = b;
      #1 last_rdy = rx_ready;
      chk("R4 rx_ready vs occupancy", {31'd0, last_rdy}, {31'd0, m_cnt < 8});
      @(negedge clk);
      rx_valid = 1'b0;
      if (last_rdy) begin
         m_mem[m_wp] = b;
         m_wp = (m_wp + 1) % 8;
         m_cnt++;
      end
   endtask

   task automatic pop_check();
      logic [31:0] d;
      logic [31:0] e;
      e = {24'd0, m_mem[(m_wp - m_cnt + 8) % 8]};
      bus_read(4'h0, d);
      if (m_cnt > 0) begin
         chk("R3 receive order", d, e);
         m_cnt--;
      end else begin
         chk("R5 empty read stale data", d, e);
      end
   endtask

   task automatic stat_check(input string req, input logic [31:0] mask, input logic [31:0] exp);
      logic [31:0] d;
      bus_read(4'h8, d);
      chk(req, d & mask, exp);
      chk("R13 error and upper status bits zero", d >> 5, 32'd0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !done) begin
         total++;
         bad++;
         $display("FAIL watchdog R1 actual=%0d expected=finished", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) m_mem[i] = 8'h00;
      void'($urandom(32'h00C0FFEE));
      idle(3);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 rx_ready", {31'd0, rx_ready}, 32'd1);
      chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
      chk("R1 irq", {31'd0, irq}, 32'd0);
      stat_check("R1 status", 32'hFFFF_FFFF, 32'h4);
      bus_read(4'hC, rd);
      chk("R1 control", rd, 32'd0);

      // R2 decode and control storage
      bus_write(4'hF, 32'hABCD_0010);
      bus_read(4'hE, rd);
      chk("R2 control readback", rd, 32'hABCD_0010);

      // R11 / R12 pending flag with enable on
      push(8'h5A);
      idle(1);
      chk("R12 irq with enable", {31'd0, irq}, 32'd1);
      stat_check("R11 pending set by rx", 32'hFFFF_FFFF, 32'h15);
      chk("R11 cleared by status read", {31'd0, irq}, 32'd0);
      idle(1);
      chk("R11 reasserted while nonempty", {31'd0, irq}, 32'd1);
      pop_check();
      stat_check("R11 pending after pop", 32'hFFFF_FFFF, 32'h14);
      stat_check("R11 stays clear when empty", 32'hFFFF_FFFF, 32'h04);
      chk("R11 irq low", {31'd0, irq}, 32'd0);

      // R12 enable off masks the output
      bus_write(4'hC, 32'h0);
      push(8'hA1);
      idle(2);
      chk("R12 irq masked", {31'd0, irq}, 32'd0);
      stat_check("R12 pending still visible", 32'hFFFF_FFFF, 32'h15);
      pop_check();
      stat_check("R3 empty after pop", 32'h0F, 32'h04);

      // R4 full, R3 order
      for (int i = 0; i < 8; i++) push(8'h10 + 8'(i));
      stat_check("R4 full flags", 32'h0F, 32'h07);
      push(8'hEE);
      for (int i = 0; i < 8; i++) pop_check();

      // R5 empty read keeps occupancy
      pop_check();
      stat_check("R5 still empty", 32'h0F, 32'h04);
      push(8'h77);
      pop_check();

      // R6 flush
      push(8'h21); push(8'h22); push(8'h23);
      bus_write(4'hC, 32'h0000_0002);
      chk("R6 rx_ready low during flush", {31'd0, last_rdy}, 32'd0);
      m_wp = 0; m_cnt = 0;
      stat_check("R6 fifo empty after flush", 32'h0F, 32'h04);
      bus_read(4'hC, rd);
      chk("R6 control kept", rd, 32'h0000_0002);
      bus_write(4'hC, 32'h0);
      push(8'h31);
      pop_check();

      // R7 status writes ignored
      push(8'h41); push(8'h42);
      bus_write(4'h8, 32'hFFFF_FFFF);
      bus_read(4'hC, rd);
      chk("R7 control untouched", rd, 32'h0);
      stat_check("R7 fifo untouched", 32'h0F, 32'h05);
      chk("R7 tx idle", {31'd0, tx_valid}, 32'd0);
      pop_check(); pop_check();

      // R8 / R14 transmit path
      bus_write(4'h4, 32'h1234_56C3);
      chk("R8 tx_valid", {31'd0, tx_valid}, 32'd1);
      chk("R8 tx_byte", {24'd0, tx_byte}, 32'hC3);
      bus_read(4'h4, rd);
      chk("R14 tx word readback", rd, 32'h1234_56C3);
      stat_check("R8 tx full flag", 32'h0C, 32'h08);
      idle(2);
      chk("R8 byte held", {24'd0, tx_byte}, 32'hC3);
      // R9 second write while occupied
      bus_write(4'h4, 32'h0000_0099);
      chk("R9 held byte kept", {24'd0, tx_byte}, 32'hC3);
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
      chk("R8 released after ready", {31'd0, tx_valid}, 32'd0);
      stat_check("R8 tx empty flag", 32'h0C, 32'h04);

      // R10 transmit flush
      bus_write(4'h4, 32'h44);
      chk("R10 loaded", {31'd0, tx_valid}, 32'd1);
      bus_write(4'hC, 32'h1);
      chk("R10 dropped", {31'd0, tx_valid}, 32'd0);
      bus_write(4'hC, 32'h0);

      // random mix of pushes, pops and status reads
      for (int n = 0; n < 600; n++) begin
         int op;
         op = int'($urandom % 10);
         if (op < 5) push(8'($urandom));
         else if (op < 9) pop_check();
         else stat_check("R3 random status", 32'h0F, exp_stat_low(m_cnt));
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule